// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block removes echoes that stay the same from one chirp to the next. It works on a stream of complex range-bin samples. For every sample it looks up the sample from the previous chirp in the same range bin, subtracts it from the current one on the I and Q lanes, and clamps each difference to the signed sample width. A target that stays still between chirps cancels to zero. A target whose echo changes shows up as the difference.

The previous-chirp samples are held in a small store of registers with one word per range bin, 64 bins by default. Every valid input sample overwrites its own bin in the same cycle that the bin is read, so chirps may follow one another with no gap. A chirp-start marker comes with the first sample of each chirp and restarts the bin index at zero. With the enable input low, the block passes samples through unchanged. When cancelling starts there is no previous chirp to subtract yet, so the output is zero until a full chirp has been stored.

Top module: `mti_canceller`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `m_valid` is 0 and `m_i`, `m_q` and `m_bin` are 0.
- R2: With `cancel_en` low, a valid input sample appears unchanged on `m_i`/`m_q` one cycle later.
- R3: `m_valid` equals `s_valid` delayed by exactly one clock cycle. `m_bin` and `m_i`/`m_q` belong to the same sample as `m_valid`.
- R4: The bin index of a sample is 0 when `s_chirp_start` is high. Otherwise it is the previous valid sample's index plus one, modulo NBINS. It appears on `m_bin`.
- R5: With `cancel_en` high and history valid, `m_i` = current I minus the stored I of the same bin, and the same holds for Q. Identical chirps give zero output.
- R6: A difference above 2^(DATA_W-1)-1 outputs 2^(DATA_W-1)-1. A difference below -2^(DATA_W-1) outputs -2^(DATA_W-1). I and Q are clamped independently.
- R7: History becomes valid at a chirp-start marker only if an earlier chirp-start marker was seen since cancelling began. While history is not valid and `cancel_en` is high, the output is 0.
- R8: A low-to-high change of `cancel_en` (including its first high cycle after reset) clears the history. The chirp in progress and the next full chirp then output zeros.
- R9: Every valid sample is written into its bin whatever the state of `cancel_en`. A sample that arrives while the block is idle between chirps needs no gap cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cancel_en | input | 1 | 1 = cancel clutter, 0 = pass through |
| s_valid | input | 1 | Input sample valid |
| s_chirp_start | input | 1 | Marks the first sample of a chirp |
| s_i | input | DATA_W | Input in-phase sample, signed |
| s_q | input | DATA_W | Input quadrature sample, signed |
| m_valid | output | 1 | Output sample valid |
| m_bin | output | BIN_W | Range bin of the output sample |
| m_i | output | DATA_W | Output in-phase sample, signed |
| m_q | output | DATA_W | Output quadrature sample, signed |

## Verification
Random chirps with random values separate a correct per-bin subtraction from a subtraction that uses the wrong bin or the wrong chirp. Repeated identical chirps show that stationary echoes cancel to zero. Directed extreme values (full-scale positive minus full-scale negative and the reverse) tell correct clamping from wrap-around, on each lane separately. Chirps longer than the store show the index wrapping. Enable toggles at chirp edges and in the middle of a chirp separate correct history clearing and muting from a block that subtracts stale data. Random idle gaps and back-to-back chirps check that the bin index and the one-cycle latency do not depend on input timing.

// File: rtl/mti_pkg.sv
package mti_pkg;

    parameter int unsigned MTI_DATA_W = 16;
    parameter int unsigned MTI_NBINS  = 64;

    // History tracking flags of the canceller.
    typedef struct packed {
        logic en_prev;   // cancel_en seen on the previous clock
        logic seen;      // a chirp start was observed since cancelling began
        logic hist;      // the store holds a complete previous chirp
    } ctl_t;

endpackage

// File: rtl/mti_history.sv
// Per-bin previous-chirp store: combinational read, write at the clock edge.
module mti_history #(
    parameter int DATA_W = 16,
    parameter int NBINS  = 64,
    localparam int BIN_W  = $clog2(NBINS),
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic [BIN_W-1:0]  addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] store_q [NBINS];

    assign rd_word = store_q[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[addr] <= wr_word;
        end
    end

endmodule

// File: rtl/mti_satsub.sv
// Signed a - b clamped to the W-bit two's complement range.
module mti_satsub #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);

    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] full;

    always_comb begin
        full = {a[W-1], a} - {b[W-1], b};
        if (full[W] != full[W-1]) begin
            y = full[W] ? MINV : MAXV;
        end else begin
            y = full[W-1:0];
        end
    end

endmodule

// File: rtl/mti_canceller.sv
module mti_canceller #(
    parameter int DATA_W = mti_pkg::MTI_DATA_W,
    parameter int NBINS  = mti_pkg::MTI_NBINS,
    localparam int BIN_W  = $clog2(NBINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cancel_en,
    input  logic                     s_valid,
    input  logic                     s_chirp_start,
    input  logic signed [DATA_W-1:0] s_i,
    input  logic signed [DATA_W-1:0] s_q,
    output logic                     m_valid,
    output logic [BIN_W-1:0]         m_bin,
    output logic signed [DATA_W-1:0] m_i,
    output logic signed [DATA_W-1:0] m_q
);

    localparam int LANES = 2;   // lane 0 = I, lane 1 = Q

    typedef struct packed {
        mti_pkg::ctl_t           ctl;
        logic [BIN_W-1:0]        bin;    // index of the next sample
        logic                    ov;
        logic [BIN_W-1:0]        obin;
        logic [DATA_W-1:0]       oi;
        logic [DATA_W-1:0]       oq;
    } st_t;

    st_t st_d, st_q;

    logic [LANES-1:0][DATA_W-1:0] cur_lane;
    logic [LANES-1:0][DATA_W-1:0] old_lane;
    logic [LANES-1:0][DATA_W-1:0] dif_lane;
    logic [BIN_W-1:0]             bin_now;

    assign cur_lane[0] = s_i;
    assign cur_lane[1] = s_q;
    assign bin_now     = s_chirp_start ? '0 : st_q.bin;

    mti_history #(
        .DATA_W (DATA_W),
        .NBINS  (NBINS)
    ) u_hist (
        .clk     (clk),
        .addr    (bin_now),
        .wr_en   (s_valid),
        .wr_word (cur_lane),
        .rd_word (old_lane)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        mti_satsub #(
            .W (DATA_W)
        ) u_sub (
            .a (cur_lane[l]),
            .b (old_lane[l]),
            .y (dif_lane[l])
        );
    end

    always_comb begin
        logic en_rise;
        logic seen_b;
        logic hist_b;
        logic hist_now;

        st_d = st_q;

        en_rise  = cancel_en & ~st_q.ctl.en_prev;
        seen_b   = en_rise ? 1'b0 : st_q.ctl.seen;
        hist_b   = en_rise ? 1'b0 : st_q.ctl.hist;
        hist_now = s_chirp_start ? seen_b : hist_b;

        st_d.ctl.en_prev = cancel_en;
        st_d.ctl.seen    = seen_b;
        st_d.ctl.hist    = hist_b;
        st_d.ov          = s_valid;

        if (s_valid) begin
            st_d.bin  = BIN_W'(bin_now + 1'b1);
            st_d.obin = bin_now;
            if (s_chirp_start) begin
                st_d.ctl.seen = 1'b1;
                st_d.ctl.hist = seen_b;
            end
            if (!cancel_en) begin
                st_d.oi = cur_lane[0];
                st_d.oq = cur_lane[1];
            end else if (!hist_now) begin
                st_d.oi = '0;
                st_d.oq = '0;
            end else begin
                st_d.oi = dif_lane[0];
                st_d.oq = dif_lane[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_valid = st_q.ov;
    assign m_bin   = st_q.obin;
    assign m_i     = st_q.oi;
    assign m_q     = st_q.oq;

endmodule

// File: rtl/mti_canceller_chk.sv
module mti_canceller_chk #(
    parameter int DATA_W = 16,
    parameter int NBINS  = 64,
    localparam int BIN_W  = $clog2(NBINS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cancel_en,
    input logic                     s_valid,
    input logic                     s_chirp_start,
    input logic signed [DATA_W-1:0] s_i,
    input logic signed [DATA_W-1:0] s_q,
    input logic                     m_valid,
    input logic [BIN_W-1:0]         m_bin,
    input logic signed [DATA_W-1:0] m_i,
    input logic signed [DATA_W-1:0] m_q
);

    logic marker_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            marker_q <= 1'b0;
        end else if (s_valid && s_chirp_start) begin
            marker_q <= 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!m_valid && m_i == '0 && m_q == '0 && m_bin == '0));

    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !cancel_en) |=> (m_i == $past(s_i) && m_q == $past(s_q)));

    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |=> m_valid);

    a_r3_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> !m_valid);

    a_r4_bin_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_chirp_start) |=> (m_bin == '0));

    a_r4_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_chirp_start && marker_q)
        |=> (m_bin == BIN_W'($past(m_bin) + 1'b1)));

    a_r8_rise_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && $rose(cancel_en)) |=> (m_i == '0 && m_q == '0));

endmodule

bind mti_canceller mti_canceller_chk #(
    .DATA_W (DATA_W),
    .NBINS  (NBINS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cancel_en     (cancel_en),
    .s_valid       (s_valid),
    .s_chirp_start (s_chirp_start),
    .s_i           (s_i),
    .s_q           (s_q),
    .m_valid       (m_valid),
    .m_bin         (m_bin),
    .m_i           (m_i),
    .m_q           (m_q)
);

// File: tb/sim_mti_canceller.sv
module sim_mti_canceller;

    localparam int  CLK_PERIOD = 10;
    localparam int  DW   = 16;
    localparam int  NB   = 64;
    localparam int  BW   = $clog2(NB);
    localparam int  MAXV = 32767;
    localparam int  MINV = -32768;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cancel_en = 1'b0;
    logic                 s_valid = 1'b0;
    logic                 s_chirp_start = 1'b0;
    logic signed [DW-1:0] s_i = '0;
    logic signed [DW-1:0] s_q = '0;
    logic                 m_valid;
    logic [BW-1:0]        m_bin;
    logic signed [DW-1:0] m_i;
    logic signed [DW-1:0] m_q;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference state
    int mi [NB];
    int mq [NB];
    int m_binidx = 0;
    bit m_en = 1'b0;
    bit m_seen = 1'b0;
    bit m_hist = 1'b0;
    bit m_rise_mute = 1'b0;

    int pat_i [NB];
    int pat_q [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    mti_canceller #(.DATA_W(DW), .NBINS(NB)) u0 (
        .clk (clk), .rst_n (rst_n), .cancel_en (cancel_en),
        .s_valid (s_valid), .s_chirp_start (s_chirp_start),
        .s_i (s_i), .s_q (s_q),
        .m_valid (m_valid), .m_bin (m_bin), .m_i (m_i), .m_q (m_q)
    );

    function automatic int sat16(input int d);
        if (d > MAXV) return MAXV;
        if (d < MINV) return MINV;
        return d;
    endfunction

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle (called at a negedge), check the result at the next negedge.
    task automatic step(input bit e, input bit v, input bit f, input int ri, input int rq);
        bit    en_rise, seen_b, hist_b, hist_now, clamped;
        int    bin_now, ei, eq, di, dq;
        string tag;

        cancel_en     = e;
        s_valid       = v;
        s_chirp_start = f;
        s_i           = DW'(ri);
        s_q           = DW'(rq);

        en_rise  = e && !m_en;
        seen_b   = en_rise ? 1'b0 : m_seen;
        hist_b   = en_rise ? 1'b0 : m_hist;
        if (en_rise) m_rise_mute = 1'b1;
        bin_now  = f ? 0 : m_binidx;
        hist_now = f ? seen_b : hist_b;
        ei = 0; eq = 0; tag = "R5";
        if (!e) begin
            ei = ri; eq = rq; tag = "R2";
        end else if (!hist_now) begin
            tag = m_rise_mute ? "R8" : "R7";
        end else begin
            m_rise_mute = 1'b0;
            di = ri - mi[bin_now];
            dq = rq - mq[bin_now];
            ei = sat16(di);
            eq = sat16(dq);
            clamped = (ei != di) || (eq != dq);
            tag = clamped ? "R6" : "R5";
        end

        @(negedge clk);
        chk(m_valid == v, "R3 valid", int'(m_valid), int'(v));
        if (v) begin
            chk(int'(m_bin) == bin_now, "R4 bin", int'(m_bin), bin_now);
            chk(int'(m_i) == ei, {tag, " I"}, int'(m_i), ei);
            chk(int'(m_q) == eq, {tag, " Q"}, int'(m_q), eq);
        end

        m_en = e;
        if (v) begin
            mi[bin_now] = ri;   // R9: stored whatever the enable
            mq[bin_now] = rq;
            m_binidx = (bin_now + 1) % NB;
            if (f) begin
                m_hist = seen_b;
                m_seen = 1'b1;
            end else begin
                m_hist = hist_b;
                m_seen = seen_b;
            end
        end else begin
            m_hist = hist_b;
            m_seen = seen_b;
        end
    endtask

    task automatic send_chirp(input bit e, input int n, input bit gaps);
        for (int k = 0; k < n; k++) begin
            if (gaps && ($urandom % 4 == 0)) step(e, 1'b0, 1'b0, 0, 0);
            step(e, 1'b1, k == 0, pat_i[k % NB], pat_q[k % NB]);
        end
    endtask

    task automatic new_pat();
        for (int k = 0; k < NB; k++) begin
            pat_i[k] = rnd16();
            pat_q[k] = rnd16();
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0a11));
        for (int k = 0; k < NB; k++) begin mi[k] = 0; mq[k] = 0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(m_valid == 1'b0, "R1 valid", int'(m_valid), 0);
        chk(m_i == '0 && m_q == '0, "R1 data", int'(m_i), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_valid == 1'b0, "R1 valid after release", int'(m_valid), 0);
        chk(m_bin == '0, "R1 bin", int'(m_bin), 0);

        // R2/R9: pass-through fills the whole store
        new_pat();
        send_chirp(1'b0, NB, 1'b0);
        send_chirp(1'b0, NB, 1'b1);

        // R8: enable rise, same data muted; then R5 differences
        send_chirp(1'b1, NB, 1'b0);
        new_pat();
        send_chirp(1'b1, NB, 1'b1);
        // R5: stationary chirp cancels to zero
        send_chirp(1'b1, NB, 1'b0);

        // R6: saturation both directions on each lane
        pat_i[0] = MAXV; pat_q[0] = MINV; pat_i[1] = MINV; pat_q[1] = MAXV;
        pat_i[2] = 100;  pat_q[2] = -100;
        send_chirp(1'b1, 3, 1'b0);
        pat_i[0] = MINV; pat_q[0] = MAXV; pat_i[1] = MAXV; pat_q[1] = MINV;
        pat_i[2] = -32700; pat_q[2] = 32700;
        send_chirp(1'b1, 3, 1'b0);

        // R4: chirp longer than the store wraps the index
        new_pat();
        send_chirp(1'b1, NB + 6, 1'b0);
        send_chirp(1'b1, NB + 6, 1'b1);

        // R8: enable dropped mid-chirp and raised again
        new_pat();
        for (int k = 0; k < 10; k++) step(k < 5, 1'b1, k == 0, pat_i[k], pat_q[k]);
        for (int k = 10; k < 20; k++) step(1'b1, 1'b1, 1'b0, pat_i[k], pat_q[k]);
        send_chirp(1'b1, 20, 1'b0);
        send_chirp(1'b1, 20, 1'b0);

        // Random mix
        begin
            bit e = 1'b1;
            int left = 0;
            for (int n = 0; n < 4000; n++) begin
                bit v, f;
                int ri, rq;
                if ($urandom % 97 == 0) e = !e;
                v = ($urandom % 4) != 0;
                f = 1'b0;
                if (v) begin
                    if (left == 0) begin
                        f = 1'b1;
                        left = 8 + int'($urandom % 57);
                    end
                    left--;
                end
                if ($urandom % 4 == 0) begin
                    ri = mi[f ? 0 : m_binidx];
                    rq = mq[f ? 0 : m_binidx];
                end else begin
                    ri = rnd16();
                    rq = rnd16();
                end
                step(e, v, f, ri, rq);
            end
        end

        summary();
    end

endmodule